// File: doc/BRIEF.md
# Power-On Reset One-Shot Timer

This block keeps the processor core in reset for a fixed number of cycles of a dedicated on-chip RC clock. The delay gives the supply and the main oscillator time to settle before any instruction runs. Three events start the delay: power-good returning after a power failure, a watchdog timeout, and recovery from stop mode. Stop-mode recovery only starts the delay when the stop-mode control bit (bit 5 of the stop-mode register) is set. When that bit is clear, recovery bypasses the delay.

The block runs entirely in the RC clock domain. The power-good level, the two event pulses and the control bit all pass through two-flop synchronizers. While power-good is low, every register is held cleared asynchronously, so reset is asserted at once without waiting for a clock. The controller has three named states:

- `ST_OFF`: power is not good.
- `ST_COUNT`: the delay is running.
- `ST_RUN`: reset is released.

Its transitions are:

- **power-up**: `ST_OFF` to `ST_COUNT` when the synchronized power-good is high.
- **release**: `ST_COUNT` to `ST_RUN` when the count reaches `DELAY_CYC-1`.
- **retrigger**: from `ST_RUN` or `ST_COUNT` to `ST_COUNT` with the count cleared, on any accepted event.
- **brown-out**: from any state to `ST_OFF` when power-good is lost.

Top module: `por_oneshot`

## Requirements
- R1: While `pwr_good` is low, `rst_active` is 1, with no clock edge needed.
- R2: After `pwr_good` rises, `rst_active` stays 1 until exactly `DELAY_CYC+3` rising edges of `rc_clk` have passed. It then becomes 0. This count is 2 synchronizer stages, 1 edge to enter counting, and `DELAY_CYC` counted edges.
- R3: From the release state, a rising edge on `wdt_expire` drives `rst_active` to 1 after the 3rd `rc_clk` edge. `rst_active` returns to 0 after the `DELAY_CYC+3`-th edge, counted from the pulse.
- R4: With `stop_delay_en` = 1, a rising edge on `stop_wake` gives the same reset interval as R3.
- R5: With `stop_delay_en` = 0, a rising edge on `stop_wake` leaves `rst_active` at 0.
- R6: An accepted event that arrives while the delay is running restarts the count from zero. `rst_active` then falls `DELAY_CYC+3` edges after that latest event.
- R7: Only the rising edge of an event input triggers. An input held high for longer than the delay produces one interval, and its falling edge has no effect.
- R8: Once released, `rst_active` stays 0 as long as no event arrives and `pwr_good` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rc_clk | input | 1 | Dedicated RC oscillator clock |
| pwr_good | input | 1 | Supply-good level, asynchronous; low clears the block |
| stop_wake | input | 1 | Stop-mode recovery event, asynchronous, rising edge |
| wdt_expire | input | 1 | Watchdog timeout event, asynchronous, rising edge |
| stop_delay_en | input | 1 | Stop-mode register bit 5: 1 applies the delay after recovery |
| rst_active | output | 1 | 1 while the processor must be held in reset |

## Verification
The bench measures the exact edge on which reset releases after power-up, after each event type, and after a retrigger in mid-count. A counter with an off-by-one compare, or a missing synchronizer stage, misses the expected count by one. A design that does not clear its counter on a retrigger releases too early. A stop-mode recovery with the control bit clear must leave reset low; a design that ignores the bit would pulse reset. A watchdog line held high must give one interval, not a repeat interval or a trigger on its falling edge. Finally, dropping power-good while running must raise reset before the next clock edge; a design that synchronizes the assertion would show 0 there.

// File: rtl/por_pkg.sv
package por_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_COUNT = 2'd1,
        ST_RUN   = 2'd2
    } por_state_e;
endpackage

// File: rtl/por_sync.sv
module por_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/por_edge.sv
module por_edge (
    input  logic clk,
    input  logic clr_n,
    input  logic lvl,
    output logic rise
);
    logic lvl_d;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) lvl_d <= 1'b0;
        else        lvl_d <= lvl;
    end

    assign rise = lvl & ~lvl_d;
endmodule

// File: rtl/por_fsm.sv
module por_fsm
    import por_pkg::*;
#(
    parameter int DELAY_CYC = 5000,
    localparam int CW = $clog2(DELAY_CYC + 1)
) (
    input  logic clk,
    input  logic clr_n,
    input  logic pg_ok,
    input  logic trig,
    output logic rst_active
);
    localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

    por_state_e    state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_OFF: begin
                if (pg_ok) begin
                    state_nx = ST_COUNT;
                    cnt_nx   = '0;
                end
            end
            ST_COUNT: begin
                if (!pg_ok) begin
                    state_nx = ST_OFF;
                end else if (trig) begin
                    cnt_nx = '0;
                end else if (cnt == LAST) begin
                    state_nx = ST_RUN;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            ST_RUN: begin
                if (!pg_ok) begin
                    state_nx = ST_OFF;
                end else if (trig) begin
                    state_nx = ST_COUNT;
                    cnt_nx   = '0;
                end
            end
            default: state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            state <= ST_OFF;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        rst_active = (state != ST_RUN);
    end

    p_count_bound_r2: assert property (@(posedge clk) disable iff (!clr_n)
        state == ST_COUNT |-> cnt <= LAST)
        else $error("count exceeded delay");

    p_release_r2: assert property (@(posedge clk) disable iff (!clr_n)
        (state == ST_COUNT && cnt == LAST && !trig && pg_ok) |=> state == ST_RUN)
        else $error("no release at end of delay");

    p_restart_r6: assert property (@(posedge clk) disable iff (!clr_n)
        (trig && pg_ok && state != ST_OFF) |=> (state == ST_COUNT && cnt == '0))
        else $error("event did not restart count");

    p_run_holds_r8: assert property (@(posedge clk) disable iff (!clr_n)
        (state == ST_RUN && !trig && pg_ok) |=> state == ST_RUN)
        else $error("left run state without cause");
endmodule

// File: rtl/por_oneshot.sv
module por_oneshot #(
    parameter int DELAY_CYC = 5000,
    parameter int SYNC_STAGES = 2
) (
    input  logic rc_clk,
    input  logic pwr_good,
    input  logic stop_wake,
    input  logic wdt_expire,
    input  logic stop_delay_en,
    output logic rst_active
);
    logic pg_s, wake_s, wdt_s, en_s;
    logic wake_rise, wdt_rise, trig;

    por_sync #(.STAGES(SYNC_STAGES)) u_pg   (.clk(rc_clk), .clr_n(pwr_good), .d(1'b1),          .q(pg_s));
    por_sync #(.STAGES(SYNC_STAGES)) u_wake (.clk(rc_clk), .clr_n(pwr_good), .d(stop_wake),     .q(wake_s));
    por_sync #(.STAGES(SYNC_STAGES)) u_wdt  (.clk(rc_clk), .clr_n(pwr_good), .d(wdt_expire),    .q(wdt_s));
    por_sync #(.STAGES(SYNC_STAGES)) u_en   (.clk(rc_clk), .clr_n(pwr_good), .d(stop_delay_en), .q(en_s));

    por_edge u_wake_e (.clk(rc_clk), .clr_n(pwr_good), .lvl(wake_s), .rise(wake_rise));
    por_edge u_wdt_e  (.clk(rc_clk), .clr_n(pwr_good), .lvl(wdt_s),  .rise(wdt_rise));

    assign trig = wdt_rise | (wake_rise & en_s);

    por_fsm #(.DELAY_CYC(DELAY_CYC)) u_fsm (
        .clk        (rc_clk),
        .clr_n      (pwr_good),
        .pg_ok      (pg_s),
        .trig       (trig),
        .rst_active (rst_active)
    );

    always_ff @(posedge rc_clk) begin
        if (pwr_good === 1'b0)
            p_off_holds_r1: assert (rst_active) else $error("reset low without power");
    end

    p_bypass_r5: assert property (@(posedge rc_clk) disable iff (!pwr_good)
        (pg_s && !rst_active && wake_rise && !en_s && !wdt_rise) |=> !rst_active)
        else $error("bypassed recovery asserted reset");

    p_level_r7: assert property (@(posedge rc_clk) disable iff (!pwr_good)
        (wdt_s && $past(wdt_s)) |-> !wdt_rise)
        else $error("held level retriggered");
endmodule

// File: tb/sim_por_oneshot.sv
module sim_por_oneshot;
    localparam int D = 12;
    localparam int EXP = D + 3;

    logic clk = 1'b0;
    logic pg = 1'b0, wake = 1'b0, wdt = 1'b0, en = 1'b0;
    logic rst;
    int vectors = 0, miscompares = 0;
    bit done = 0;

    always #10 clk = ~clk;

    por_oneshot #(.DELAY_CYC(D)) u0 (
        .rc_clk(clk), .pwr_good(pg), .stop_wake(wake),
        .wdt_expire(wdt), .stop_delay_en(en), .rst_active(rst)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // sel: 0 pwr_good rise, 1 watchdog, 2 stop wake. hold 0 = leave high
    task automatic fire(input int sel, input int hold, input int lim,
                        output int n, output int first_hi);
        bit seen;
        n = 0; first_hi = 0; seen = rst;
        @(negedge clk);
        case (sel)
            0: pg = 1'b1;
            1: wdt = 1'b1;
            default: wake = 1'b1;
        endcase
        for (int i = 0; i < lim; i++) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (n == hold) begin wdt = 1'b0; wake = 1'b0; end
            if (rst && !seen) begin seen = 1; first_hi = n; end
            if (seen && !rst) break;
        end
    endtask

    task automatic idle_low(input string tag, input int cyc);
        int bad = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (rst) bad++;
        end
        chk(tag, bad, 0);
    endtask

    task automatic t_off;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R1 reset while power low", rst, 1);
        end
    endtask

    task automatic t_powerup;
        int n, f;
        fire(0, 0, 100, n, f);
        chk("R2 power-up release edge", n, EXP);
        idle_low("R8 stays released", 20);
    endtask

    task automatic t_wdt;
        int n, f;
        fire(1, 1, 100, n, f);
        chk("R3 watchdog assert edge", f, 3);
        chk("R3 watchdog release edge", n, EXP);
        idle_low("R8 stays released after watchdog", 10);
    endtask

    task automatic t_stop_on;
        int n, f;
        @(negedge clk); en = 1'b1;
        repeat (4) @(negedge clk);
        fire(2, 2, 100, n, f);
        chk("R4 stop recovery assert edge", f, 3);
        chk("R4 stop recovery release edge", n, EXP);
    endtask

    task automatic t_stop_bypass;
        int n, f;
        @(negedge clk); en = 1'b0;
        repeat (4) @(negedge clk);
        fire(2, 2, EXP + 10, n, f);
        chk("R5 bypass no reset", f, 0);
        idle_low("R5 bypass stays low", 10);
    endtask

    task automatic t_restart;
        int n, f;
        @(negedge clk); en = 1'b1;
        repeat (4) @(negedge clk);
        fire(1, 1, 8, n, f);
        chk("R6 first event took effect", rst, 1);
        fire(2, 1, 100, n, f);
        chk("R6 release counted from second event", n, EXP);
    endtask

    task automatic t_level;
        int n, f;
        fire(1, 0, 100, n, f);
        chk("R7 held level single interval", n, EXP);
        idle_low("R7 no retrigger while held", 15);
        @(negedge clk); wdt = 1'b0;
        idle_low("R7 falling edge ignored", 10);
    endtask

    task automatic t_brownout;
        @(negedge clk);
        pg = 1'b0;
        #1;
        chk("R1 immediate assert on power loss", rst, 1);
        t_off();
        t_powerup();
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        t_off();
        t_powerup();
        t_wdt();
        t_stop_on();
        t_stop_bypass();
        t_restart();
        t_level();
        t_brownout();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule